// File: doc/BRIEF.md
# Autoboot Supervisor with Status LED

This block supervises the start-up window after reset. A countdown runs for a configurable number of seconds. The number of cycles is the seconds setting times the clock frequency parameter. While the countdown runs, a status LED blinks. A byte strobe from the serial receiver that arrives before the countdown ends cancels the automatic boot. The block then settles in a console-idle state and never starts a boot on its own until the next reset.

If the countdown ends first, the block sends a single-cycle request to the flash image loader and waits for the loader's verdict. A successful load with a non-zero image size produces a single-cycle application launch pulse. A successful load that reports a zero size is refused and falls back to the console. A loader error or a system fault freezes the block in a fault state. In that state the LED is lit steadily and a 3-bit error code is held until reset.

Top module: `boot_supervisor`

## Requirements
- R1: While reset is held and directly after its release: led is 1, load_req and launch are 0, err_valid is 0, err_code is 0 and console_idle is 0.
- R2: During the countdown the LED inverts once every CLK_HZ/BLINK_DIV rising edges, starting from 1, so after k edges it equals 1 XOR bit 0 of floor(k / (CLK_HZ/BLINK_DIV)).
- R3: With no received byte, load_req is 1 for exactly one cycle, after rising edge number CLK_HZ*TIMEOUT_S counted from reset release.
- R4: rx_valid seen on an edge during the countdown makes console_idle 1 after that edge, and load_req stays 0 from then until reset.
- R5: If rx_valid is seen on the same edge on which the countdown expires, the abort wins and no load request is issued.
- R6: While waiting for the loader, load_ok with a non-zero load_size gives a launch pulse of one cycle after that edge. From then on, every input is ignored: no further pulse, no error and no console entry.
- R7: load_ok with load_size equal to zero gives no launch and moves the block to console_idle.
- R8: Once a fault is entered, led is 1 on every cycle and no longer blinks.
- R9: load_err while waiting for the loader sets err_valid and latches load_err_code. The codes are 0 bad signature, 1 image too large, 2 checksum mismatch, 3 flash not responding, 4 instruction memory read-only. The code is held until reset.
- R10: sys_fault during the countdown, while loading or in the console sets err_valid with err_code 5.
- R11: In the fault state, rx_valid, load_ok, load_err and sys_fault have no effect: err_code, err_valid, launch and console_idle keep their values.
- R12: If load_err and load_ok arrive on the same edge, the error is taken and no launch occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Serial receiver byte-valid strobe |
| load_ok | input | 1 | Loader finished with a verified image |
| load_size | input | SIZE_W | Image size reported with load_ok |
| load_err | input | 1 | Loader failed |
| load_err_code | input | 3 | Loader failure code, valid with load_err |
| sys_fault | input | 1 | System fault indication |
| led | output | 1 | Status LED, active high |
| load_req | output | 1 | One-cycle request to load from flash |
| launch | output | 1 | One-cycle application launch pulse |
| console_idle | output | 1 | Autoboot aborted, console idle |
| err_valid | output | 1 | Fault latched |
| err_code | output | 3 | Latched fault code |

## Verification
The bench builds the block with CLK_HZ=40, TIMEOUT_S=2 and BLINK_DIV=4. The timeout is then 80 cycles and the LED inverts every 10 cycles. With these values a full countdown, every blink edge and the exact expiry edge can each be checked cycle by cycle within a short run. The small window also allows many randomly placed abort and fault points, plus the case where the abort and the expiry fall on the same edge. Loader outcomes are covered for every loader error code, for a zero and a non-zero size, and for an error and a success on the same edge.

// File: rtl/boot_supervisor_pkg.sv
// Shared types for the autoboot supervisor.
// Assumes a 3-bit fault code space; values 6 and 7 are passed through unchanged.
package boot_supervisor_pkg;

    typedef enum logic [2:0] {
        BS_COUNTDOWN = 3'd0,
        BS_LOADING   = 3'd1,
        BS_CONSOLE   = 3'd2,
        BS_RUNNING   = 3'd3,
        BS_FAULT     = 3'd4
    } bs_state_t;

    typedef enum logic [2:0] {
        FC_SIGNATURE = 3'd0,
        FC_TOO_LARGE = 3'd1,
        FC_CHECKSUM  = 3'd2,
        FC_NO_FLASH  = 3'd3,
        FC_READ_ONLY = 3'd4,
        FC_SYSTEM    = 3'd5
    } fault_code_t;

endpackage

// File: rtl/bs_cycle_div.sv
// Enabled cycle divider: raises hit on every LIMIT-th enabled cycle.
// Assumes LIMIT >= 1; the count holds while en is low.
module bs_cycle_div #(
    parameter longint unsigned LIMIT = 4,
    parameter int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic hit
);
    logic [W-1:0] cnt;

    // Terminal count reached in an enabled cycle.
    assign hit = en && (cnt == W'(LIMIT - 1));

    // Advance the count and wrap on the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            if (hit) cnt <= '0;
            else     cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bs_led_drive.sv
// Status LED driver: lit after reset, inverts on toggle, forced on by force_on.
// Assumes force_on takes priority over toggle in the same cycle.
module bs_led_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    input  logic force_on,
    output logic led
);
    // LED state register.
    always_ff @(posedge clk) begin
        if (!rst_n)        led <= 1'b1;
        else if (force_on) led <= 1'b1;
        else if (toggle)   led <= ~led;
    end
endmodule

// File: rtl/bs_fault_latch.sv
// Captures the first fault code and holds it until reset.
// Assumes set is a single-cycle strobe; later strobes are ignored.
module bs_fault_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set,
    input  logic [2:0] code_in,
    output logic       valid,
    output logic [2:0] code
);
    // First-fault capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            code  <= 3'd0;
        end else if (set && !valid) begin
            valid <= 1'b1;
            code  <= code_in;
        end
    end
endmodule

// File: rtl/bs_boot_fsm.sv
// Boot sequencing state machine.
// Assumes tmo_hit is asserted only while counting down. A byte strobe beats
// the timeout on the same edge. A loader error beats a loader success.
module bs_boot_fsm
    import boot_supervisor_pkg::*;
#(
    parameter int SIZE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmo_hit,
    input  logic              rx_valid,
    input  logic              load_ok,
    input  logic [SIZE_W-1:0] load_size,
    input  logic              load_err,
    input  logic [2:0]        load_err_code,
    input  logic              sys_fault,
    output logic              counting,
    output logic              blinking,
    output logic              frozen,
    output logic              console_idle,
    output logic              load_req,
    output logic              launch,
    output logic              fault_set,
    output logic [2:0]        fault_code
);
    bs_state_t state, state_nxt;
    logic      load_req_nxt, launch_nxt;

    // Decoded state flags for the surrounding datapath.
    assign counting     = (state == BS_COUNTDOWN);
    assign blinking     = (state == BS_COUNTDOWN) || (state == BS_LOADING) || (state == BS_CONSOLE);
    assign frozen       = (state == BS_FAULT);
    assign console_idle = (state == BS_CONSOLE);

    // Next-state and strobe decode.
    always_comb begin
        state_nxt    = state;
        load_req_nxt = 1'b0;
        launch_nxt   = 1'b0;
        fault_set    = 1'b0;
        fault_code   = 3'd0;
        if (blinking && sys_fault) begin
            fault_set  = 1'b1;
            fault_code = FC_SYSTEM;
            state_nxt  = BS_FAULT;
        end else begin
            case (state)
                BS_COUNTDOWN: begin
                    if (rx_valid) begin
                        state_nxt = BS_CONSOLE;
                    end else if (tmo_hit) begin
                        state_nxt    = BS_LOADING;
                        load_req_nxt = 1'b1;
                    end
                end
                BS_LOADING: begin
                    if (load_err) begin
                        fault_set  = 1'b1;
                        fault_code = load_err_code;
                        state_nxt  = BS_FAULT;
                    end else if (load_ok) begin
                        if (load_size != '0) begin
                            launch_nxt = 1'b1;
                            state_nxt  = BS_RUNNING;
                        end else begin
                            state_nxt  = BS_CONSOLE;
                        end
                    end
                end
                default: state_nxt = state;
            endcase
        end
    end

    // State and output strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BS_COUNTDOWN;
            load_req <= 1'b0;
            launch   <= 1'b0;
        end else begin
            state    <= state_nxt;
            load_req <= load_req_nxt;
            launch   <= launch_nxt;
        end
    end
endmodule

// File: rtl/boot_supervisor.sv
// Autoboot supervisor top: countdown, blink timer, LED, sequencing FSM, fault latch.
// Assumes CLK_HZ is divisible by BLINK_DIV and that all inputs are synchronous.
module boot_supervisor #(
    parameter longint unsigned CLK_HZ    = 100_000_000,
    parameter longint unsigned TIMEOUT_S = 8,
    parameter longint unsigned BLINK_DIV = 4,
    parameter int              SIZE_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              load_ok,
    input  logic [SIZE_W-1:0] load_size,
    input  logic              load_err,
    input  logic [2:0]        load_err_code,
    input  logic              sys_fault,
    output logic              led,
    output logic              load_req,
    output logic              launch,
    output logic              console_idle,
    output logic              err_valid,
    output logic [2:0]        err_code
);
    localparam longint unsigned TMO_CYC   = CLK_HZ * TIMEOUT_S;
    localparam longint unsigned BLINK_CYC = CLK_HZ / BLINK_DIV;

    logic counting, blinking, frozen, tmo_hit, blink_hit, fault_set;
    logic [2:0] fault_code;

    bs_cycle_div #(.LIMIT(TMO_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .en(counting), .hit(tmo_hit)
    );

    bs_cycle_div #(.LIMIT(BLINK_CYC)) u_blink (
        .clk(clk), .rst_n(rst_n), .en(blinking), .hit(blink_hit)
    );

    bs_boot_fsm #(.SIZE_W(SIZE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tmo_hit(tmo_hit), .rx_valid(rx_valid),
        .load_ok(load_ok), .load_size(load_size), .load_err(load_err),
        .load_err_code(load_err_code), .sys_fault(sys_fault),
        .counting(counting), .blinking(blinking), .frozen(frozen),
        .console_idle(console_idle), .load_req(load_req), .launch(launch),
        .fault_set(fault_set), .fault_code(fault_code)
    );

    bs_led_drive u_led (
        .clk(clk), .rst_n(rst_n), .toggle(blink_hit),
        .force_on(frozen | fault_set), .led(led)
    );

    bs_fault_latch u_err (
        .clk(clk), .rst_n(rst_n), .set(fault_set), .code_in(fault_code),
        .valid(err_valid), .code(err_code)
    );
endmodule

// File: rtl/boot_supervisor_chk.sv
// Port-level temporal checks for the autoboot supervisor, bound to the top.
module boot_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       led,
    input logic       load_req,
    input logic       launch,
    input logic       console_idle,
    input logic       err_valid,
    input logic [2:0] err_code
);
    assert_load_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> !load_req);

    assert_console_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        console_idle |=> (console_idle || err_valid));

    assert_console_noload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        console_idle |-> !load_req);

    assert_launch_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

    assert_fault_led_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> led);

    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> (err_valid && $stable(err_code)));

    assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (!launch && !load_req));
endmodule

bind boot_supervisor boot_supervisor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .led(led), .load_req(load_req), .launch(launch),
    .console_idle(console_idle), .err_valid(err_valid), .err_code(err_code)
);

// File: tb/boot_supervisor_bench.sv
`timescale 1ns/1ps
module boot_supervisor_bench;
    localparam int TMO = 80;
    localparam int BLK = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, load_ok = 1'b0, load_err = 1'b0, sys_fault = 1'b0;
    logic [31:0] load_size = '0;
    logic [2:0]  load_err_code = '0;
    logic        led, load_req, launch, console_idle, err_valid;
    logic [2:0]  err_code;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    boot_supervisor #(.CLK_HZ(40), .TIMEOUT_S(2), .BLINK_DIV(4), .SIZE_W(32)) u_boot_supervisor (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .load_ok(load_ok),
        .load_size(load_size), .load_err(load_err), .load_err_code(load_err_code),
        .sys_fault(sys_fault), .led(led), .load_req(load_req), .launch(launch),
        .console_idle(console_idle), .err_valid(err_valid), .err_code(err_code)
    );

    function automatic logic exp_led(input int k);
        return 1'b1 ^ (((k / BLK) % 2) == 1);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        rx_valid = 0; load_ok = 0; load_err = 0; sys_fault = 0;
        load_size = '0; load_err_code = '0;
        rst_n = 0;
        steps(3);
        rst_n = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        int bad;
        void'($urandom(32'd2024));

        // R1 reset state
        do_reset();
        chk("R1 led", led, 1);
        chk("R1 load_req", load_req, 0);
        chk("R1 launch", launch, 0);
        chk("R1 err_valid", err_valid, 0);
        chk("R1 err_code", err_code, 0);
        chk("R1 console_idle", console_idle, 0);

        // R2 / R3 full countdown
        for (int n = 1; n <= TMO; n++) begin
            step();
            chk("R2 blink", led, exp_led(n));
            chk("R3 timeout edge", load_req, (n == TMO));
        end
        step();
        chk("R3 single pulse", load_req, 0);

        // R4 random abort points
        for (int it = 0; it < 8; it++) begin
            do_reset();
            k = $urandom_range(TMO - 1, 1);
            steps(k - 1);
            rx_valid = 1; step(); rx_valid = 0;
            chk("R4 console entry", console_idle, 1);
            bad = 0;
            for (int n = 0; n < 2 * TMO; n++) begin
                step();
                if (load_req !== 1'b0 || console_idle !== 1'b1) bad++;
            end
            chk("R4 no load after abort", bad, 0);
        end

        // R5 abort on expiry edge
        do_reset();
        steps(TMO - 1);
        rx_valid = 1; step(); rx_valid = 0;
        chk("R5 abort beats timeout", load_req, 0);
        chk("R5 console", console_idle, 1);

        // R6 launch with non-zero size, then inputs ignored
        for (int it = 0; it < 4; it++) begin
            do_reset();
            steps(TMO);
            chk("R6 load_req", load_req, 1);
            steps($urandom_range(5, 0));
            load_size = $urandom | 32'h4;
            load_ok = 1; step(); load_ok = 0;
            chk("R6 launch", launch, 1);
            step();
            chk("R6 launch pulse end", launch, 0);
            rx_valid = 1; sys_fault = 1; load_err = 1; load_ok = 1; load_err_code = 3'd2;
            step();
            rx_valid = 0; sys_fault = 0; load_err = 0; load_ok = 0;
            step();
            chk("R6 ignored err", err_valid, 0);
            chk("R6 ignored launch", launch, 0);
            chk("R6 ignored console", console_idle, 0);
        end

        // R7 zero size refused
        do_reset();
        steps(TMO + 2);
        load_size = '0; load_ok = 1; step(); load_ok = 0;
        chk("R7 no launch", launch, 0);
        chk("R7 console", console_idle, 1);

        // R8 / R9 every loader error code
        for (int c = 0; c < 5; c++) begin
            do_reset();
            steps(TMO + $urandom_range(3, 0));
            load_err = 1; load_err_code = 3'(c); step(); load_err = 0; load_err_code = 3'd7;
            chk("R9 err_valid", err_valid, 1);
            chk("R9 err_code", err_code, c);
            bad = 0;
            for (int n = 0; n < 3 * BLK; n++) begin
                step();
                if (led !== 1'b1 || err_code !== 3'(c)) bad++;
            end
            chk("R8 steady led", bad, 0);
        end

        // R10 system fault in countdown, loading, console
        do_reset();
        steps($urandom_range(TMO - 2, 1));
        sys_fault = 1; step(); sys_fault = 0;
        chk("R10 countdown fault", err_code, 5);
        chk("R10 countdown valid", err_valid, 1);
        do_reset();
        steps(TMO + 1);
        sys_fault = 1; step(); sys_fault = 0;
        chk("R10 loading fault", err_code, 5);
        do_reset();
        steps(5);
        rx_valid = 1; step(); rx_valid = 0;
        steps(7);
        sys_fault = 1; step(); sys_fault = 0;
        chk("R10 console fault", err_code, 5);
        chk("R10 led", led, 1);

        // R11 fault ignores inputs
        do_reset();
        steps(TMO);
        load_err = 1; load_err_code = 3'd2; step(); load_err = 0;
        bad = 0;
        for (int n = 0; n < 20; n++) begin
            sys_fault = 1'($urandom); load_ok = 1'($urandom); rx_valid = 1'($urandom);
            load_err = 1'($urandom); load_err_code = 3'($urandom); load_size = $urandom | 1;
            step();
            if (err_code !== 3'd2 || launch !== 1'b0 || console_idle !== 1'b0 || err_valid !== 1'b1) bad++;
        end
        sys_fault = 0; load_ok = 0; rx_valid = 0; load_err = 0;
        chk("R11 frozen", bad, 0);

        // R12 error beats success
        do_reset();
        steps(TMO);
        load_size = 32'h100; load_ok = 1; load_err = 1; load_err_code = 3'd3;
        step();
        load_ok = 0; load_err = 0;
        chk("R12 err_valid", err_valid, 1);
        chk("R12 err_code", err_code, 3);
        chk("R12 no launch", launch, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule